// File: doc/BRIEF.md
# Converter Status Frame Serializer

This block assembles the 64-slot serial output frame that an audio converter sends back to its host, then shifts it out one bit per serial bit strobe. The frame carries the left sample, a status byte with a data-valid flag and two clip flags, a 4-bit fault code and a 4-bit revision code, the right sample, and the levels of four digital input pins.

A one-cycle `frame_sync` pulse captures every field input and the serial mode in a single clock edge. Slot 1 appears on `sdout` in the next cycle. Each later clock with `bit_en` high moves the output on by one slot. After slot 64 has been stepped past, the line returns to idle.

The captured frame is also presented as a parallel snapshot on `frame_word`, with a one-cycle `snap_valid` strobe. The fault codes for a bad sync pulse and for an out-of-range serial clock drive a mute request, and that request holds until the next frame boundary. In the two narrower serial modes, some digital input slots are not reported and are sent as zero.

Top module: `status_frame_tx`

## Requirements
- R1: Slots 1 to 16 carry `left_sample`, most significant bit first, in two's complement. Slot s is `frame_word[64-s]`.
- R2: Slots 17 to 21 are zero. Slot 22 carries `adc_valid`, slot 23 carries `clip_left` and slot 24 carries `clip_right`.
- R3: Slots 25 to 28 carry `err_code` and slots 29 to 32 carry `ver_code`, each most significant bit first.
- R4: Slots 33 to 48 carry `right_sample`, most significant bit first. Slots 49 to 60 are zero.
- R5: Slots 61 to 64 carry `dig_in[0]`, `dig_in[1]`, `dig_in[2]` and `dig_in[3]` in that order when `ser_mode` is 0 or 1.
- R6: With `ser_mode` = 2, slots 63 and 64 are zero. With `ser_mode` = 3, slots 62 to 64 are zero.
- R7: All fields and the mode are captured on the clock edge that samples `frame_sync`. Input changes after that edge leave `frame_word` and `sdout` unchanged until the next sync.
- R8: `mute_req` is 1 exactly when the captured fault code is 4'b0010 or 4'b0011, and it holds until the next sync. Codes 4'b0000 and 4'b0001 give `mute_req` = 0.
- R9: After reset: `sdout`, `frame_active`, `snap_valid` and `mute_req` are 0, and `frame_word` holds a fault code of 0000, a revision code of 0001 and zeros elsewhere.
- R10: While a frame is active, the slot advances only on clocks with `bit_en` high. After the 64th step, `frame_active` and `sdout` are 0.
- R11: `snap_valid` is 1 for exactly the one cycle after a sync, and `frame_word` then holds the captured frame.
- R12: A sync that arrives mid-frame abandons the current frame. Slot 1 of the new frame appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | Frame start pulse; captures all fields |
| bit_en | input | 1 | Serial bit strobe; advances one slot |
| left_sample | input | 16 | Left sample, two's complement |
| right_sample | input | 16 | Right sample, two's complement |
| adc_valid | input | 1 | Converter data valid flag |
| clip_left | input | 1 | Left clip flag |
| clip_right | input | 1 | Right clip flag |
| err_code | input | 4 | Fault code |
| ver_code | input | 4 | Revision code |
| dig_in | input | 4 | Digital input pin levels, bit 0 = first pin |
| ser_mode | input | 2 | Serial mode code, 0 to 3 |
| sdout | output | 1 | Serial frame data |
| frame_active | output | 1 | Frame being shifted |
| snap_valid | output | 1 | One-cycle snapshot strobe |
| frame_word | output | 64 | Captured frame, slot 1 at bit 63 |
| mute_req | output | 1 | Mute request from the captured fault code |

## Verification
The assertions check on every cycle that the reserved slots of the snapshot stay zero and that the line is low while idle. They also check that the snapshot strobe follows a sync, that slot 1 leads each frame, that the snapshot holds between syncs, that the output stays put on clocks without a strobe, that the mode-2 mask is applied, and that the mute request matches the captured fault code. Only the bench's scenarios can show that every one of the 64 slots lands in its position for each serial mode, that inputs scrambled mid-frame do not disturb the frame in flight, that a frame cut short restarts cleanly, and that the frame ends after exactly 64 steps.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
    parameter int SAMPLE_W = 16;
    parameter int CODE_W   = 4;
    parameter int DI_N     = 4;
    parameter int STAT_W   = 8;
    parameter int FRAME_W  = 64;

    localparam int IDX_W     = $clog2(FRAME_W);
    localparam int LEFT_LO   = FRAME_W - SAMPLE_W;
    localparam int CLIPR_POS = LEFT_LO - STAT_W;
    localparam int CLIPL_POS = CLIPR_POS + 1;
    localparam int VALID_POS = CLIPR_POS + 2;
    localparam int ERR_HI    = CLIPR_POS - 1;
    localparam int ERR_LO    = ERR_HI - CODE_W + 1;
    localparam int VER_HI    = ERR_LO - 1;
    localparam int VER_LO    = VER_HI - CODE_W + 1;
    localparam int RIGHT_HI  = VER_LO - 1;
    localparam int RIGHT_LO  = RIGHT_HI - SAMPLE_W + 1;

    localparam logic [CODE_W-1:0] ERR_NONE   = 'd0;
    localparam logic [CODE_W-1:0] ERR_CTRL   = 'd1;
    localparam logic [CODE_W-1:0] ERR_SYNC   = 'd2;
    localparam logic [CODE_W-1:0] ERR_CLK    = 'd3;
    localparam logic [CODE_W-1:0] VER_RESET  = 'd1;

    typedef enum logic [1:0] {
        MODE_1 = 2'd0,
        MODE_2 = 2'd1,
        MODE_3 = 2'd2,
        MODE_4 = 2'd3
    } mode_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
        logic                clip_l;
        logic                clip_r;
        logic [CODE_W-1:0]   err;
        logic [CODE_W-1:0]   ver;
        logic [DI_N-1:0]     di;
    } fields_t;

    function automatic logic is_mute_code(input logic [CODE_W-1:0] code);
        return (code == ERR_SYNC) || (code == ERR_CLK);
    endfunction
endpackage

// File: rtl/sfx_di_mask.sv
module sfx_di_mask
    import sfx_pkg::*;
#(
    parameter int N = DI_N
) (
    input  mode_t          mode,
    input  logic [N-1:0]   di,
    output logic [N-1:0]   di_vis
);
    logic [N-1:0] keep;

    always_comb begin
        keep = '1;
        for (int k = 0; k < N; k++) begin
            unique case (mode)
                MODE_3:  keep[k] = (k < 2);
                MODE_4:  keep[k] = (k < 1);
                default: keep[k] = 1'b1;
            endcase
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign di_vis[i] = di[i] & keep[i];
    end
endmodule

// File: rtl/sfx_frame_pack.sv
module sfx_frame_pack
    import sfx_pkg::*;
(
    input  fields_t              fld,
    input  mode_t                mode,
    output logic [FRAME_W-1:0]   word
);
    logic [DI_N-1:0] di_vis;
    logic [DI_N-1:0] di_slots;

    sfx_di_mask #(.N(DI_N)) u_mask (
        .mode   (mode),
        .di     (fld.di),
        .di_vis (di_vis)
    );

    // first pin goes to the earliest of the trailing slots
    for (genvar i = 0; i < DI_N; i++) begin : g_order
        assign di_slots[DI_N-1-i] = di_vis[i];
    end

    always_comb begin
        word                       = '0;
        word[FRAME_W-1:LEFT_LO]    = fld.left;
        word[VALID_POS]            = fld.valid;
        word[CLIPL_POS]            = fld.clip_l;
        word[CLIPR_POS]            = fld.clip_r;
        word[ERR_HI:ERR_LO]        = fld.err;
        word[VER_HI:VER_LO]        = fld.ver;
        word[RIGHT_HI:RIGHT_LO]    = fld.right;
        word[DI_N-1:0]             = di_slots;
    end
endmodule

// File: rtl/sfx_slot_ctrl.sv
module sfx_slot_ctrl
    import sfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [IDX_W-1:0]  idx,
    output logic              active
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             active;
    } ctl_t;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (load) begin
            ctl_d.idx    = '0;
            ctl_d.active = 1'b1;
        end else if (step && ctl_q.active) begin
            if (ctl_q.idx == LAST) begin
                ctl_d.idx    = '0;
                ctl_d.active = 1'b0;
            end else begin
                ctl_d.idx = ctl_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign idx    = ctl_q.idx;
    assign active = ctl_q.active;
endmodule

// File: rtl/status_frame_tx.sv
module status_frame_tx
    import sfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_sync,
    input  logic                 bit_en,
    input  logic [15:0]          left_sample,
    input  logic [15:0]          right_sample,
    input  logic                 adc_valid,
    input  logic                 clip_left,
    input  logic                 clip_right,
    input  logic [3:0]           err_code,
    input  logic [3:0]           ver_code,
    input  logic [3:0]           dig_in,
    input  logic [1:0]           ser_mode,
    output logic                 sdout,
    output logic                 frame_active,
    output logic                 snap_valid,
    output logic [63:0]          frame_word,
    output logic                 mute_req
);
    typedef struct packed {
        fields_t fld;
        mode_t   mode;
        logic    snap;
    } cap_t;

    localparam fields_t FLD_RST = '{
        left:   '0,
        right:  '0,
        valid:  1'b0,
        clip_l: 1'b0,
        clip_r: 1'b0,
        err:    ERR_NONE,
        ver:    VER_RESET,
        di:     '0
    };

    cap_t             cap_d, cap_q;
    fields_t          fld_in;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] sel;
    logic             active;
    logic [FRAME_W-1:0] word;

    always_comb begin
        fld_in.left   = left_sample;
        fld_in.right  = right_sample;
        fld_in.valid  = adc_valid;
        fld_in.clip_l = clip_left;
        fld_in.clip_r = clip_right;
        fld_in.err    = err_code;
        fld_in.ver    = ver_code;
        fld_in.di     = dig_in;
    end

    always_comb begin
        cap_d      = cap_q;
        cap_d.snap = frame_sync;
        if (frame_sync) begin
            cap_d.fld  = fld_in;
            cap_d.mode = mode_t'(ser_mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.fld  <= FLD_RST;
            cap_q.mode <= MODE_1;
            cap_q.snap <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    sfx_frame_pack u_pack (
        .fld  (cap_q.fld),
        .mode (cap_q.mode),
        .word (word)
    );

    sfx_slot_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_sync),
        .step   (bit_en),
        .idx    (idx),
        .active (active)
    );

    assign sel          = IDX_W'(FRAME_W - 1) - idx;
    assign sdout        = active & word[sel];
    assign frame_active = active;
    assign snap_valid   = cap_q.snap;
    assign frame_word   = word;
    assign mute_req     = is_mute_code(cap_q.fld.err);
endmodule

// File: rtl/sfx_chk.sv
module sfx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_sync,
    input logic        bit_en,
    input logic [1:0]  ser_mode,
    input logic        sdout,
    input logic        frame_active,
    input logic        snap_valid,
    input logic [63:0] frame_word,
    input logic        mute_req
);
    // R10
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |-> !sdout);

    // R11
    snap_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |-> $past(frame_sync));

    // R12
    slot_one_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_sync) |-> (frame_active && sdout == frame_word[63]));

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_sync) |-> $stable(frame_word));

    // R2
    status_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_word[47:43] == 5'd0);

    // R4
    tail_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_word[15:4] == 12'd0);

    // R6
    mode3_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_sync) && $past(ser_mode) == 2'd2) |-> frame_word[1:0] == 2'd0);

    // R8
    mute_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req == (frame_word[39:36] == 4'd2 || frame_word[39:36] == 4'd3));

    // R10
    no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && !bit_en && !frame_sync) |=> $stable(sdout));
endmodule

bind status_frame_tx sfx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_sync   (frame_sync),
    .bit_en       (bit_en),
    .ser_mode     (ser_mode),
    .sdout        (sdout),
    .frame_active (frame_active),
    .snap_valid   (snap_valid),
    .frame_word   (frame_word),
    .mute_req     (mute_req)
);

// File: tb/sim_status_frame_tx.sv
module sim_status_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs = 1'b0, be = 1'b0;
    logic [15:0] lf = '0, rt = '0;
    logic        v = 1'b0, cl = 1'b0, cr = 1'b0;
    logic [3:0]  ec = '0, vc = '0, di = '0;
    logic [1:0]  md = '0;
    logic        sdout, frame_active, snap_valid, mute_req;
    logic [63:0] frame_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    status_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(fs), .bit_en(be),
        .left_sample(lf), .right_sample(rt), .adc_valid(v),
        .clip_left(cl), .clip_right(cr), .err_code(ec), .ver_code(vc),
        .dig_in(di), .ser_mode(md), .sdout(sdout),
        .frame_active(frame_active), .snap_valid(snap_valid),
        .frame_word(frame_word), .mute_req(mute_req)
    );

    function automatic logic [63:0] exp_frame(
        input logic [15:0] l, input logic [15:0] r, input logic va,
        input logic c_l, input logic c_r, input logic [3:0] e,
        input logic [3:0] vr, input logic [3:0] d, input logic [1:0] m);
        logic [63:0] f;
        f = '0;
        for (int s = 1; s <= 64; s++) begin
            logic b;
            b = 1'b0;
            if (s <= 16) b = l[16-s];
            else if (s == 22) b = va;
            else if (s == 23) b = c_l;
            else if (s == 24) b = c_r;
            else if (s >= 25 && s <= 28) b = e[28-s];
            else if (s >= 29 && s <= 32) b = vr[32-s];
            else if (s >= 33 && s <= 48) b = r[48-s];
            else if (s >= 61) begin
                int k;
                k = s - 61;
                b = d[k];
                if (m == 2'd2 && k >= 2) b = 1'b0;
                if (m == 2'd3 && k >= 1) b = 1'b0;
            end
            f[64-s] = b;
        end
        return f;
    endfunction

    function automatic string req_of(input int s, input logic [1:0] m);
        if (s <= 16) return "R1";
        if (s <= 24) return "R2";
        if (s <= 32) return "R3";
        if (s <= 60) return "R4";
        if (m >= 2'd2) return "R6";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exv);
        checks++;
        if (act !== exv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    task automatic scramble();
        lf = 16'($urandom); rt = 16'($urandom);
        v = 1'($urandom); cl = 1'($urandom); cr = 1'($urandom);
        ec = 4'($urandom); vc = 4'($urandom); di = 4'($urandom);
        md = 2'($urandom);
    endtask

    // abort_at = 0 shifts the whole frame, otherwise stops before that slot's step
    task automatic run_frame(input logic [15:0] l, input logic [15:0] r,
        input logic va, input logic c_l, input logic c_r, input logic [3:0] e,
        input logic [3:0] vr, input logic [3:0] d, input logic [1:0] m,
        input int abort_at);
        logic [63:0] ex;
        logic        mute_exp;
        @(negedge clk);
        lf = l; rt = r; v = va; cl = c_l; cr = c_r; ec = e; vc = vr; di = d; md = m;
        fs = 1'b1;
        @(negedge clk);
        fs = 1'b0;
        ex = exp_frame(l, r, va, c_l, c_r, e, vr, d, m);
        mute_exp = (e == 4'd2) || (e == 4'd3);
        check("R11", 64'(snap_valid), 64'd1);
        check("R11", frame_word, ex);
        check("R8", 64'(mute_req), 64'(mute_exp));
        check("R12", 64'(frame_active), 64'd1);
        for (int s = 1; s <= 64; s++) begin
            if (s == 2) check("R11", 64'(snap_valid), 64'd0);
            check(req_of(s, m), 64'(sdout), 64'(ex[64-s]));
            if (s == abort_at) return;
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                check("R10", 64'(sdout), 64'(ex[64-s]));
            end
            if (s == 30) scramble();
            be = 1'b1;
            @(negedge clk);
            be = 1'b0;
        end
        check("R10", 64'(frame_active), 64'd0);
        check("R10", 64'(sdout), 64'd0);
        check("R7", frame_word, ex);
        check("R8", 64'(mute_req), 64'(mute_exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", 64'(sdout), 64'd0);
        check("R9", 64'(frame_active), 64'd0);
        check("R9", 64'(snap_valid), 64'd0);
        check("R9", 64'(mute_req), 64'd0);
        check("R9", frame_word, 64'h0000_0001_0000_0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", frame_word, 64'h0000_0001_0000_0000);
        // R10: strobes while idle move nothing
        be = 1'b1;
        repeat (3) @(negedge clk);
        be = 1'b0;
        check("R10", 64'(sdout), 64'd0);

        // directed corners: extreme samples, each mode, each named fault code
        run_frame(16'h8000, 16'h7FFF, 1, 1, 0, 4'd0, 4'd1, 4'hF, 2'd0, 0);
        run_frame(16'hFFFF, 16'h0001, 0, 0, 1, 4'd1, 4'd1, 4'hF, 2'd1, 0);
        run_frame(16'hA5C3, 16'h3C5A, 1, 0, 1, 4'd2, 4'd1, 4'hF, 2'd2, 0);
        run_frame(16'h0000, 16'hFFFF, 1, 1, 1, 4'd3, 4'd0, 4'hF, 2'd3, 0);
        run_frame(16'h1234, 16'h8001, 0, 1, 1, 4'd15, 4'd15, 4'h9, 2'd0, 0);
        // R12: abandon a frame midway, then a full one
        run_frame(16'hFFFF, 16'hFFFF, 1, 1, 1, 4'd2, 4'd7, 4'hF, 2'd0, 10);
        run_frame(16'h0F0F, 16'hF0F0, 0, 0, 0, 4'd0, 4'd1, 4'h6, 2'd1, 0);
        run_frame(16'hFFFF, 16'hFFFF, 1, 1, 1, 4'd3, 4'd7, 4'hF, 2'd2, 40);
        run_frame(16'h0001, 16'h8000, 1, 0, 0, 4'd1, 4'd1, 4'hE, 2'd3, 0);

        // constrained random frames
        for (int n = 0; n < 30; n++) begin
            logic [3:0] e;
            e = ($urandom % 3 != 0) ? 4'($urandom % 4) : 4'($urandom);
            run_frame(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), e, 4'($urandom), 4'($urandom), 2'($urandom),
                      ($urandom % 6 == 0) ? int'($urandom % 64) + 1 : 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule